// File: doc/BRIEF.md
# Supply Monitor Control and Status Register

This block is the software-visible face of a low-supply (brown-out) detector. An analog comparator, outside the block, reports whether the I/O supply sits above a chosen threshold. The block brings that comparator output into the clock domain. It holds the enable and threshold-select controls that steer the comparator. It latches a sticky low-supply flag when the supply drops, and raises level interrupts toward a normal and a fast interrupt controller.

Software reaches the block through one 32-bit register at a fixed address. Bit 3 shows the live comparator state. Bit 2 selects the threshold. Bit 1 enables the monitor. Bit 0 is the flag, which software clears by writing 1. A clear only takes effect once the supply has recovered, so an interrupt handler cannot lose a low-supply event that is still going on.

Top module: `supmon_csr`

## Requirements
- R1: After reset, a read of address 0xFFFF0440 returns 0x00000008. Both interrupt outputs, `trip_sel` and `mon_en` are 0.
- R2: Bit 3 reads 1 whenever the monitor is disabled. When the monitor is enabled, bit 3 follows the comparator input through a two-flop synchroniser: a change on `cmp_in` shows on a read after the second rising edge.
- R3: Bits 2 and 1 are written from bus bits 2 and 1 and read back as written. Bit 2 drives `trip_sel` (0 = lower threshold, 1 = higher threshold). Bit 1 drives `mon_en`.
- R4: While enabled, a high-to-low change of the synchronised comparator sets bit 0. The flag reads 1 after the third rising edge following the fall of `cmp_in`.
- R5: Writing 1 to bit 0 clears the flag only while bit 3 reads 1. While bit 3 reads 0, the write is ignored and the flag stays 1.
- R6: Writing 0 to bit 0 leaves the flag unchanged.
- R7: While disabled, the flag is never set. Enabling the monitor while the comparator is already low does not set the flag.
- R8: `irq_norm` and `irq_fast` are registered levels. Each equals, one cycle later, the flag ANDed with its own mask input (`mask_norm`, `mask_fast`).
- R9: Bits 31:4 read 0 and ignore writes. Any other address reads 0 and ignores writes.
- R10: When a falling edge is detected in the same cycle as a write of 1 to bit 0, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator output, 1 = supply above threshold |
| bus_addr | input | 32 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| mask_norm | input | 1 | Normal interrupt-enable mask bit |
| mask_fast | input | 1 | Fast interrupt-enable mask bit |
| irq_norm | output | 1 | Normal interrupt level |
| irq_fast | output | 1 | Fast interrupt level |
| trip_sel | output | 1 | Threshold select toward the comparator |
| mon_en | output | 1 | Monitor enable toward the comparator |

## Verification
Hardware setting the flag and a software write-1 clear can land in the same cycle. The bench provokes this by timing a clear write onto the exact edge where the synchronised comparator is first seen low. It then expects the flag to read 1. The constrained-random phase also lets clear writes collide with comparator falls at random. Every cycle it compares the read data and both interrupts with a bench model built from the requirements.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    localparam int          DATA_W    = 32;
    localparam logic [31:0] CSR_ADDR  = 32'hFFFF_0440;
    localparam int          FLAG_BIT  = 0;
    localparam int          EN_BIT    = 1;
    localparam int          TRIP_BIT  = 2;
    localparam int          STAT_BIT  = 3;
    localparam int          USED_BITS = 4;

    typedef struct packed {
        logic trip_hi;
        logic enable;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{trip_hi: 1'b0, enable: 1'b0};

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.trip_hi = w[TRIP_BIT];
        c.enable  = w[EN_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] view_word(input logic stat,
                                                    input ctrl_t c,
                                                    input logic flag);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[STAT_BIT] = stat;
        w[TRIP_BIT] = c.trip_hi;
        w[EN_BIT]   = c.enable;
        w[FLAG_BIT] = flag;
        return w;
    endfunction

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RESET_VAL;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RESET_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/supmon_flag.sv
module supmon_flag (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic cmp_sync,
    input  logic stat_high,
    input  logic clr_req,
    output logic flag_q
);
    logic cmp_prev;
    logic fall_evt;

    assign fall_evt = enable & cmp_prev & ~cmp_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_prev <= 1'b1;
            flag_q   <= 1'b0;
        end else begin
            cmp_prev <= cmp_sync;
            if (fall_evt)
                flag_q <= 1'b1;
            else if (clr_req && stat_high)
                flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/supmon_irq.sv
module supmon_irq #(
    parameter int NUM_OUT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flag,
    input  logic [NUM_OUT-1:0] mask,
    output logic [NUM_OUT-1:0] irq_q
);
    genvar g;
    generate
        for (g = 0; g < NUM_OUT; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) irq_q[g] <= 1'b0;
                else     irq_q[g] <= flag & mask[g];
            end
        end
    endgenerate
endmodule

// File: rtl/supmon_csr.sv
module supmon_csr
    import supmon_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] BASE_ADDR   = CSR_ADDR,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              mask_norm,
    input  logic              mask_fast,
    output logic              irq_norm,
    output logic              irq_fast,
    output logic              trip_sel,
    output logic              mon_en
);
    localparam int IRQ_N = 2;
    localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR[ADDR_W-1:0];

    ctrl_t            ctrl_q;
    logic             cmp_sync;
    logic             stat_high;
    logic             flag_q;
    logic             addr_hit;
    logic             wr_hit;
    logic             clr_req;
    logic [IRQ_N-1:0] irq_vec;
    logic             unused_wdata_hi;

    assign addr_hit        = (bus_addr == MY_ADDR);
    assign wr_hit          = bus_wr & addr_hit;
    assign clr_req         = wr_hit & bus_wdata[FLAG_BIT];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:USED_BITS];

    supmon_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(cmp_in),
        .d_sync (cmp_sync)
    );

    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= CTRL_RESET;
        else if (wr_hit) ctrl_q <= ctrl_from_word(bus_wdata);
    end

    assign stat_high = ~ctrl_q.enable | cmp_sync;

    supmon_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .enable   (ctrl_q.enable),
        .cmp_sync (cmp_sync),
        .stat_high(stat_high),
        .clr_req  (clr_req),
        .flag_q   (flag_q)
    );

    supmon_irq #(.NUM_OUT(IRQ_N)) u_irq (
        .clk  (clk),
        .rst  (rst),
        .flag (flag_q),
        .mask ({mask_fast, mask_norm}),
        .irq_q(irq_vec)
    );

    assign irq_norm  = irq_vec[0];
    assign irq_fast  = irq_vec[1];
    assign trip_sel  = ctrl_q.trip_hi;
    assign mon_en    = ctrl_q.enable;
    assign bus_rdata = addr_hit ? view_word(stat_high, ctrl_q, flag_q) : '0;
endmodule

// File: rtl/supmon_csr_chk.sv
module supmon_csr_chk #(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_0440
) (
    input logic              clk,
    input logic              rst,
    input logic              mon_en,
    input logic              cmp_sync,
    input logic              flag_q,
    input logic              clr_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              mask_norm,
    input logic              mask_fast,
    input logic              irq_norm,
    input logic              irq_fast
);
    localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR[ADDR_W-1:0];

    p_stat_forced_r2: assert property (@(posedge clk) disable iff (rst)
        (!mon_en && bus_addr == MY_ADDR) |-> bus_rdata[3]);

    p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
        (mon_en && $fell(cmp_sync)) |=> flag_q);

    p_clr_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_q && clr_req && mon_en && !cmp_sync) |=> flag_q);

    p_no_set_off_r7: assert property (@(posedge clk) disable iff (rst)
        (!mon_en && !flag_q) |=> !flag_q);

    p_irq_norm_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_norm == $past(flag_q && mask_norm)));

    p_irq_fast_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_fast == $past(flag_q && mask_fast)));

    p_high_bits_r9: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:4] == '0);
endmodule

bind supmon_csr supmon_csr_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mon_en   (mon_en),
    .cmp_sync (cmp_sync),
    .flag_q   (flag_q),
    .clr_req  (clr_req),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .mask_norm(mask_norm),
    .mask_fast(mask_fast),
    .irq_norm (irq_norm),
    .irq_fast (irq_fast)
);

// File: tb/supmon_csr_bench.sv
`timescale 1ns/1ps
module supmon_csr_bench;
    localparam logic [31:0] A = 32'hFFFF_0440;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_in = 1'b1;
    logic [31:0] bus_addr = A;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mask_norm = 1'b0;
    logic        mask_fast = 1'b0;
    logic        irq_norm, irq_fast, trip_sel, mon_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    supmon_csr u_supmon_csr (
        .clk(clk), .rst(rst), .cmp_in(cmp_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mask_norm(mask_norm), .mask_fast(mask_fast), .irq_norm(irq_norm),
        .irq_fast(irq_fast), .trip_sel(trip_sel), .mon_en(mon_en)
    );

    // bench model built from the requirements
    logic m_s0, m_s1, m_prev, m_en, m_trip, m_flag, m_irqn, m_irqf;

    function automatic logic m_stat(input logic en, input logic s1);
        return !en || s1;
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [31:0] addr);
        if (addr != A) return 32'h0;
        return {28'h0, m_stat(m_en, m_s1), m_trip, m_en, m_flag};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s0 <= 1; m_s1 <= 1; m_prev <= 1; m_en <= 0; m_trip <= 0;
            m_flag <= 0; m_irqn <= 0; m_irqf <= 0;
        end else begin
            m_s0 <= cmp_in; m_s1 <= m_s0; m_prev <= m_s1;
            if (bus_wr && bus_addr == A) begin
                m_en <= bus_wdata[1]; m_trip <= bus_wdata[2];
            end
            if (m_en && m_prev && !m_s1) m_flag <= 1;
            else if (bus_wr && bus_addr == A && bus_wdata[0] && m_stat(m_en, m_s1)) m_flag <= 0;
            m_irqn <= m_flag & mask_norm;
            m_irqf <= m_flag & mask_fast;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic wr(input logic [31:0] addr, input logic [31:0] d);
        bus_addr = addr; bus_wdata = d; bus_wr = 1'b1;
        cyc(1);
        bus_wr = 1'b0; bus_addr = A;
    endtask

    task automatic rd(input logic [31:0] exp, input string tag);
        bus_addr = A; #0.1;
        check(bus_rdata, exp, tag);
    endtask

    initial begin
        void'($urandom(32'd4242));
        cyc(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(32'h8, "R1 reset value");
        check({30'h0, irq_norm, irq_fast}, 32'h0, "R1 irq low");
        check({30'h0, trip_sel, mon_en}, 32'h0, "R1 controls low");
        // R3 control bits
        mask_norm = 1'b1;
        wr(A, 32'h6);
        rd(32'hE, "R3 readback");
        check({30'h0, trip_sel, mon_en}, 32'h3, "R3 outputs");
        // R2 / R4 latency of a fall
        cmp_in = 1'b0;
        cyc(1); rd(32'hE, "R2 one edge, still high");
        cyc(1); rd(32'h6, "R2 status low after two edges");
        cyc(1); rd(32'h7, "R4 flag set on third edge");
        check({31'h0, irq_norm}, 32'h0, "R8 irq not yet");
        cyc(1);
        check({30'h0, irq_norm, irq_fast}, 32'h2, "R8 norm only");
        // R5 clear blocked while low
        wr(A, 32'h7);
        rd(32'h7, "R5 clear ignored while low");
        // R6 zero write
        wr(A, 32'h6);
        rd(32'h7, "R6 zero write");
        // R5 clear after recovery
        cmp_in = 1'b1; cyc(3);
        rd(32'hF, "R2 status high again");
        wr(A, 32'h7);
        rd(32'hE, "R5 clear works when high");
        cyc(1);
        check({31'h0, irq_norm}, 32'h0, "R8 irq drops");
        // R10 set and clear in one cycle
        cmp_in = 1'b0; cyc(2);
        wr(A, 32'h7);
        rd(32'h7, "R10 set wins");
        // R7 disabled
        cmp_in = 1'b1; cyc(3);
        wr(A, 32'h1);
        rd(32'h8, "R7 disable and clear");
        cmp_in = 1'b0; cyc(4);
        rd(32'h8, "R7 no set while off, R2 forced high");
        wr(A, 32'h2); cyc(3);
        rd(32'h2, "R7 enable while low no set");
        // R9 upper bits and other addresses
        wr(A, 32'hFFFF_FFF6);
        rd(32'h6, "R9 upper bits ignored");
        wr(A + 32'h4, 32'h0);
        rd(32'h6, "R9 other address write ignored");
        bus_addr = A + 32'h4; #0.1;
        check(bus_rdata, 32'h0, "R9 other address reads zero");
        bus_addr = A;
        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 6 == 0) cmp_in = ~cmp_in;
            bus_wr    = ($urandom % 4 == 0);
            bus_addr  = ($urandom % 8 == 0) ? A ^ 32'h10 : A;
            bus_wdata = $urandom;
            mask_norm = $urandom % 2;
            mask_fast = $urandom % 2;
            #0.1;
            check(bus_rdata, exp_rdata(bus_addr), "R4/R5/R10 random read");
            check({31'h0, irq_norm}, {31'h0, m_irqn}, "R8 random norm");
            check({31'h0, irq_fast}, {31'h0, m_irqf}, "R8 random fast");
            check({30'h0, trip_sel, mon_en}, {30'h0, m_trip, m_en}, "R3 random controls");
            @(negedge clk);
        end
        bus_wr = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule